// File: doc/BRIEF.md
# Streaming NTT Transform Sequencer

This block is the top-level control state machine of a 256-point number-theoretic transform engine. The engine has eight butterfly layers and 32 butterfly units working in parallel. A host raises `start` with a transform direction on `mode_in`. The sequencer accepts the command only when it is idle, the input coefficient FIFO holds data and the output FIFO has room. After accepting, it runs one fixed schedule that takes exactly 40 cycles:

- one cycle that clears the stage and memory pointers;
- 32 compute cycles, 4 per layer across 8 layers;
- a 5-cycle wait while the butterfly pipeline fills;
- one handshake cycle;
- a single-cycle `done`.

During the compute cycles the sequencer drives a layer index and a cycle-within-layer index, which the address and twiddle generators use. For the whole run it broadcasts the latched direction to every processing element. The arithmetic and the coefficient data path are outside this block.

Because the schedule is fixed, the flags, `start` and `mode_in` are read only at the moment a command is accepted. This gives a latency that is known in advance, and it stays the same whatever the FIFO status does during the run.

Top module: `ntt_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is idle. Idle means `busy`, `done`, `ptr_clear` and `compute_valid` are 0, `layer_idx` and `beat_idx` are 0, and `mode_out` is 0. No command is accepted during reset.
- R2: A command is accepted at a clock edge only if the sequencer is idle, `start`=1, `in_empty`=0 and `out_full`=0. In any other case the sequencer stays idle with `busy`=0.
- R3: `ptr_clear` is 1 for exactly one cycle, the first cycle after the accepting edge, and is 0 at all other times.
- R4: `compute_valid` is 1 for exactly 32 consecutive cycles, starting the cycle after `ptr_clear`. These are run cycles 2 to 33, counting the `ptr_clear` cycle as run cycle 1.
- R5: In compute cycle k (k = 0 to 31), `layer_idx` = k/4 and `beat_idx` = k mod 4. Whenever `compute_valid` is 0, both indices are 0.
- R6: `busy` is 1 for exactly 40 cycles after the accepting edge. `done` is 1 only in the 40th of these cycles. Run cycles 34 to 38 are the pipeline-fill wait and run cycle 39 is the handshake cycle.
- R7: `mode_out` takes the value of `mode_in` at the accepting edge (0 = forward, 1 = inverse). It holds that value through the whole run and the idle time that follows, until the next command is accepted. `mode_in` has no effect at any other time.
- R8: While `busy` is 1, `start`, `in_empty`, `out_full` and `mode_in` have no effect on any output or on the 40-cycle latency.
- R9: A `start` presented during the `done` cycle is ignored, and the following cycle is idle. A `start` presented in that idle cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command request |
| mode_in | input | 1 | Requested direction: 0 forward, 1 inverse |
| in_empty | input | 1 | Input coefficient FIFO is empty |
| out_full | input | 1 | Output result FIFO is full |
| busy | output | 1 | A transform run is in progress |
| ptr_clear | output | 1 | One-cycle pulse that clears stage and memory pointers |
| compute_valid | output | 1 | Butterfly array is issuing work this cycle |
| layer_idx | output | 3 | Current layer, 0 to 7 |
| beat_idx | output | 2 | Cycle within the current layer, 0 to 3 |
| mode_out | output | 1 | Direction broadcast to all processing elements |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Every result is due at a fixed offset from the accepting edge:
- `ptr_clear` after 1 edge;
- compute cycle k after k+2 edges;
- `done` after 40 edges;
- idle again after 41 edges.

The bench counts edges from the accepting edge and samples on the falling clock between edges, so each expectation is compared in the one cycle it belongs to. While a run is in progress, the FIFO flags, `start` and `mode_in` are randomised on every cycle, which shows that none of them moves the schedule or the broadcast direction.

// File: rtl/ntt_seq_pkg.sv
// Package: shared state encoding for the transform sequencer.
// Assumes: nothing beyond 1800-2017 enum support.
package ntt_seq_pkg;

    // Phases of one transform run, in the order they occur.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_COMPUTE = 3'd2,
        ST_FILL    = 3'd3,
        ST_HAND    = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/ntt_seq_step_ctr.sv
// Module: layer / beat counter that walks the butterfly schedule.
// It is cleared by `clear`, advances on `adv`, and flags the last beat of
// the last layer. Assumes LAYERS >= 2 and BEATS >= 1.
module ntt_seq_step_ctr #(
    parameter int LAYERS  = 8,
    parameter int BEATS   = 4,
    parameter int LAYER_W = (LAYERS > 1) ? $clog2(LAYERS) : 1,
    parameter int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               adv,
    output logic [LAYER_W-1:0] layer,
    output logic [BEAT_W-1:0]  beat,
    output logic               last
);

    localparam logic [LAYER_W-1:0] LAYER_MAX = LAYER_W'(LAYERS - 1);
    localparam logic [BEAT_W-1:0]  BEAT_MAX  = BEAT_W'(BEATS - 1);

    logic beat_wrap;

    generate
        if (BEATS == 1) begin : g_single_beat
            // One beat per layer: the beat index is constant and every step wraps.
            assign beat      = '0;
            assign beat_wrap = 1'b1;
        end else begin : g_multi_beat
            logic [BEAT_W-1:0] beat_q;
            // Beat counter: restarts each layer.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    beat_q <= '0;
                end else if (adv) begin
                    beat_q <= (beat_q == BEAT_MAX) ? '0 : beat_q + BEAT_W'(1);
                end
            end
            assign beat      = beat_q;
            assign beat_wrap = (beat_q == BEAT_MAX);
        end
    endgenerate

    // Layer counter: advances when the beat counter wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            layer <= '0;
        end else if (adv && beat_wrap) begin
            layer <= (layer == LAYER_MAX) ? '0 : layer + LAYER_W'(1);
        end
    end

    assign last = beat_wrap && (layer == LAYER_MAX);

endmodule

// File: rtl/ntt_seq_mode_reg.sv
// Module: holds the transform direction that is broadcast to the processing elements.
// Loads only on an accepted command. Assumes `load` is a one-cycle strobe.
module ntt_seq_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic mode_in,
    output logic mode_q
);

    // Capture the requested direction on acceptance; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (load) begin
            mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/ntt_seq_fsm.sv
// Module: phase state machine of the sequencer.
// Order: IDLE -> LOAD -> COMPUTE (until the step counter reports last) ->
// FILL (FILL_CYC cycles) -> HAND -> DONE -> IDLE.
// Assumes FILL_CYC >= 1. Flags and start are looked at only in IDLE.
module ntt_seq_fsm
    import ntt_seq_pkg::*;
#(
    parameter int FILL_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_empty,
    input  logic       out_full,
    input  logic       sweep_last,
    output logic       accept,
    output seq_state_t state
);

    localparam int FILL_W = (FILL_CYC > 1) ? $clog2(FILL_CYC) : 1;
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(FILL_CYC - 1);

    seq_state_t        state_nx;
    logic [FILL_W-1:0] fill_cnt;

    // Acceptance: idle, a request, input data present, room for results.
    assign accept = (state == ST_IDLE) && start && !in_empty && !out_full;

    // Next-phase decode.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_LOAD;
            ST_LOAD:    state_nx = ST_COMPUTE;
            ST_COMPUTE: if (sweep_last) state_nx = ST_FILL;
            ST_FILL:    if (fill_cnt == FILL_MAX) state_nx = ST_HAND;
            ST_HAND:    state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Pipeline-fill wait counter: counts only inside FILL, zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_FILL) begin
            fill_cnt <= '0;
        end else begin
            fill_cnt <= fill_cnt + FILL_W'(1);
        end
    end

endmodule

// File: rtl/ntt_seq_ctrl.sv
// Module: top of the transform sequencer.
// It accepts a command under FIFO flow control, clears pointers, sweeps all
// layers with BEATS cycles each, waits out the butterfly fill, pulses done,
// and broadcasts the latched direction. Total run = LAYERS*BEATS + FILL_CYC + 3.
// Assumes N_POINTS is a power of two and N_POINTS/2 is a multiple of N_BFLY.
module ntt_seq_ctrl
    import ntt_seq_pkg::*;
#(
    parameter int N_POINTS = 256,
    parameter int N_BFLY   = 32,
    parameter int FILL_CYC = 5,
    localparam int LAYERS    = $clog2(N_POINTS),
    localparam int BEATS     = (N_POINTS / 2) / N_BFLY,
    localparam int LAYER_W   = (LAYERS > 1) ? $clog2(LAYERS) : 1,
    localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int TOTAL_CYC = LAYERS * BEATS + FILL_CYC + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode_in,
    input  logic               in_empty,
    input  logic               out_full,
    output logic               busy,
    output logic               ptr_clear,
    output logic               compute_valid,
    output logic [LAYER_W-1:0] layer_idx,
    output logic [BEAT_W-1:0]  beat_idx,
    output logic               mode_out,
    output logic               done
);

    seq_state_t         state;
    logic               accept;
    logic               sweep_last;
    logic [LAYER_W-1:0] layer_cnt;
    logic [BEAT_W-1:0]  beat_cnt;

    ntt_seq_fsm #(
        .FILL_CYC (FILL_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_empty   (in_empty),
        .out_full   (out_full),
        .sweep_last (sweep_last),
        .accept     (accept),
        .state      (state)
    );

    ntt_seq_step_ctr #(
        .LAYERS  (LAYERS),
        .BEATS   (BEATS),
        .LAYER_W (LAYER_W),
        .BEAT_W  (BEAT_W)
    ) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ptr_clear),
        .adv   (compute_valid),
        .layer (layer_cnt),
        .beat  (beat_cnt),
        .last  (sweep_last)
    );

    ntt_seq_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .mode_in (mode_in),
        .mode_q  (mode_out)
    );

    // Status decode from the phase register.
    assign busy          = (state != ST_IDLE);
    assign ptr_clear     = (state == ST_LOAD);
    assign compute_valid = (state == ST_COMPUTE);
    assign done          = (state == ST_DONE);

    // Indices are driven only while butterflies issue; zero otherwise.
    assign layer_idx = compute_valid ? layer_cnt : '0;
    assign beat_idx  = compute_valid ? beat_cnt  : '0;

endmodule

// File: rtl/ntt_seq_chk.sv
// Module: property checker for the sequencer, bound to the top below.
// It uses a run-length counter to check the fixed latency window.
module ntt_seq_chk #(
    parameter int LAT     = 40,
    parameter int BEATS   = 4,
    parameter int LAYER_W = 3,
    parameter int BEAT_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               mode_in,
    input logic               in_empty,
    input logic               out_full,
    input logic               busy,
    input logic               ptr_clear,
    input logic               compute_valid,
    input logic [LAYER_W-1:0] layer_idx,
    input logic [BEAT_W-1:0]  beat_idx,
    input logic               mode_out,
    input logic               done
);

    localparam logic [BEAT_W-1:0] BEAT_ONE  = BEAT_W'(1);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);

    logic [15:0] run_cnt;

    // Counts busy cycles since the run began (0 in the first busy cycle).
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 16'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!busy && !done && !mode_out));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && !in_empty && !out_full)) |=> !busy);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !in_empty && !out_full) |=> ptr_clear);

    // R3
    clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clear |=> (!ptr_clear && compute_valid));

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (compute_valid && $past(compute_valid)) |->
        (beat_idx == (($past(beat_idx) == BEAT_LAST) ? '0 : $past(beat_idx) + BEAT_ONE)));

    // R5
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !compute_valid |-> (layer_idx == '0 && beat_idx == '0));

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 16'(LAT - 1)));

    // R6
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_out));

endmodule

bind ntt_seq_ctrl ntt_seq_chk #(
    .LAT     (TOTAL_CYC),
    .BEATS   (BEATS),
    .LAYER_W (LAYER_W),
    .BEAT_W  (BEAT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mode_in       (mode_in),
    .in_empty      (in_empty),
    .out_full      (out_full),
    .busy          (busy),
    .ptr_clear     (ptr_clear),
    .compute_valid (compute_valid),
    .layer_idx     (layer_idx),
    .beat_idx      (beat_idx),
    .mode_out      (mode_out),
    .done          (done)
);

// File: tb/sim_ntt_seq_ctrl.sv
// Bench: sweeps runs in both directions with randomised flags, refusals and
// back-to-back starts. Expectations come from run-cycle arithmetic.
module sim_ntt_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_in = 1'b0;
    logic       in_empty = 1'b1;
    logic       out_full = 1'b0;
    logic       busy, ptr_clear, compute_valid, mode_out, done;
    logic [2:0] layer_idx;
    logic [1:0] beat_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    ntt_seq_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .mode_in (mode_in),
        .in_empty (in_empty), .out_full (out_full), .busy (busy),
        .ptr_clear (ptr_clear), .compute_valid (compute_valid),
        .layer_idx (layer_idx), .beat_idx (beat_idx),
        .mode_out (mode_out), .done (done)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag, input logic m);
        chk({tag, " busy"}, busy, 0);
        chk({tag, " done"}, done, 0);
        chk({tag, " ptr_clear"}, ptr_clear, 0);
        chk({tag, " compute_valid"}, compute_valid, 0);
        chk({tag, " mode_out"}, mode_out, m);
    endtask

    // One run: accept at the next edge, then check run cycles 1..40 and one idle cycle.
    task automatic run(input logic m, input bit b2b);
        start = 1'b1; mode_in = m; in_empty = 1'b0; out_full = 1'b0;
        @(posedge clk);
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            chk("R6 busy", busy, 1);
            chk("R6 done", done, (i == 40) ? 1 : 0);
            chk("R3 ptr_clear", ptr_clear, (i == 1) ? 1 : 0);
            chk("R4 compute_valid", compute_valid, (i >= 2 && i <= 33) ? 1 : 0);
            chk("R5 layer_idx", layer_idx, (i >= 2 && i <= 33) ? (i - 2) / 4 : 0);
            chk("R5 beat_idx", beat_idx, (i >= 2 && i <= 33) ? (i - 2) % 4 : 0);
            chk("R7 R8 mode_out", mode_out, m);
            // R8: disturb every input while busy
            start = 1'($urandom); mode_in = 1'($urandom);
            in_empty = 1'($urandom); out_full = 1'($urandom);
            if (i == 40) begin
                // R9: a request in the done cycle is ignored
                start = b2b; in_empty = 1'b0; out_full = 1'b0; mode_in = ~m;
            end
        end
        @(negedge clk);
        idle_chk("R9 post-done idle", m);
        start = 1'b0;
        if (!b2b) begin
            for (int j = 0; j < 2; j++) begin
                mode_in = 1'($urandom); in_empty = 1'($urandom); out_full = 1'($urandom);
                @(negedge clk);
                idle_chk("R7 idle hold", m);
            end
        end
    endtask

    initial begin
        // R1: a request during reset is not accepted
        start = 1'b1; in_empty = 1'b0; out_full = 1'b0; mode_in = 1'b1;
        repeat (3) @(negedge clk);
        idle_chk("R1 reset", 1'b0);
        chk("R1 layer_idx", layer_idx, 0);
        chk("R1 beat_idx", beat_idx, 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1 after reset", 1'b0);

        // R2: refusals with an empty input FIFO, a full output FIFO, or no request
        for (int k = 0; k < 12; k++) begin
            start    = (k >= 8) ? 1'b0 : 1'b1;
            in_empty = (k < 4) ? 1'b1 : 1'($urandom);
            out_full = (k >= 4 && k < 8) ? 1'b1 : ((k < 4) ? 1'($urandom) : 1'b0);
            mode_in  = 1'($urandom);
            @(negedge clk);
            idle_chk("R2 refuse", 1'b0);
        end

        // Sweep both directions, spaced and back-to-back runs.
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                run(1'(m), p >= 2);
            end
        end
        for (int r = 0; r < 6; r++) begin
            run(1'($urandom), 1'($urandom));
        end

        // R2 again after runs: refusal with the output FIFO full
        start = 1'b1; in_empty = 1'b0; out_full = 1'b1;
        @(negedge clk);
        chk("R2 refuse after runs busy", busy, 0);
        start = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule